// File: doc/BRIEF.md
# Read-Sequence Write-Protect Lock

This block keeps the software write-protect state of a flash array controller. Nothing in the data path can change that state. The only way to change it is a run of seven consecutive read cycles at fixed addresses.

The first six addresses are the same for both directions, and the seventh address picks the direction. A final read at 0x041A clears protection. A final read at 0x040A sets it. The block takes the already-synchronised chip-enable, output-enable and write-enable strobes and the address bus. It produces a protect flag, and it gates program and erase requests against that flag.

A read cycle is active while `ce_n` is 0, `oe_n` is 0 and `we_n` is 1. The read ends in the first clock in which `ce_n` or `oe_n` is high again. The address counted for that read is the one present in the last clock the read was active.

Top module: `rdseq_wp_lock`

## Requirements
- R1: After synchronous reset `wp_active` is 1, the matcher is at step zero, and `prog_go`, `erase_go` and `write_blocked` are 0.
- R2: Seven completed reads at 0x1823, 0x1820, 0x1822, 0x0418, 0x041B, 0x0419, 0x041A, in that order, clear `wp_active`. It reads 0 from the clock edge that closes the cycle in which the seventh read ends.
- R3: Seven completed reads at 0x1823, 0x1820, 0x1822, 0x0418, 0x041B, 0x0419, 0x040A, in that order, set `wp_active` with the same timing as R2.
- R4: A read ends when either `ce_n` or `oe_n` goes high, whichever comes first. The address counted is the one held in the read's last active clock, so an address change in the ending clock has no effect.
- R5: A completed read at an address that does not match the expected step returns the matcher to step zero. That same read is then tested as step one, so 0x1823 moves the matcher to step one.
- R6: Any clock with `ce_n` = 0 and `we_n` = 0 (a write cycle) returns the matcher to step zero, so an interrupted sequence has no effect.
- R7: `wp_active` changes only when a seventh step completes and matches. A sequence with a wrong seventh address leaves the flag as it was.
- R8: One clock after `prog_req` or `erase_req`, the block responds as follows. While protected, it pulses `write_blocked` for one clock and keeps `prog_go` and `erase_go` at 0. While unprotected, it pulses the matching go output for one clock.
- R9: A request in the same clock in which a seventh read completes is judged against the flag value from before that read.
- R10: A read held active for several clocks counts as one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Address bus |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| prog_req | input | 1 | Program request pulse |
| erase_req | input | 1 | Erase request pulse |
| prog_go | output | 1 | Program allowed, one-clock pulse |
| erase_go | output | 1 | Erase allowed, one-clock pulse |
| write_blocked | output | 1 | Request refused because the block is protected, one-clock pulse |
| wp_active | output | 1 | Write protect is on |

## Verification
Two functions can fall in one clock: completion of the seventh read, which flips the protect flag, and a program request that is gated by that flag. The bench provokes this by ending the final unlock read in the same clock in which it raises `prog_req`. It then expects `write_blocked` to pulse with no `prog_go`, while `wp_active` already reads 0 in the following clock. A second request after that must pass, which shows the flag change was real.

// File: rtl/rdseq_wp_pkg.sv
// Package: shared constants for the read-sequence write-protect lock.
// Assumes addresses of the sequence fit in 16 bits and are zero-extended.
package rdseq_wp_pkg;

    localparam int SEQ_LEN = 7;
    localparam int STEP_W  = $clog2(SEQ_LEN);

    localparam logic [15:0] TAIL_OPEN  = 16'h041A;
    localparam logic [15:0] TAIL_CLOSE = 16'h040A;

    // Address expected at each shared step (0 .. SEQ_LEN-2).
    function automatic logic [15:0] prefix_addr(input int idx);
        case (idx)
            0:       return 16'h1823;
            1:       return 16'h1820;
            2:       return 16'h1822;
            3:       return 16'h0418;
            4:       return 16'h041B;
            5:       return 16'h0419;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/rdseq_strobe_track.sv
// Module: rdseq_strobe_track
// Watches the bus strobes and produces a one-clock pulse when a read cycle
// ends, together with the address held in the read's last active clock.
// Also flags every clock of a write cycle.
// Assumes the strobes are already synchronous to clk.
module rdseq_strobe_track #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic              rd_end,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_act
);

    logic              rd_act;
    logic              rd_act_q;
    logic [ADDR_W-1:0] addr_q;

    // Decode the current bus cycle type from the strobes.
    always_comb begin
        rd_act = ~ce_n & ~oe_n & we_n;
        wr_act = ~ce_n & ~we_n;
    end

    // Remember read activity and the address of the latest active read clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            addr_q   <= '0;
        end else begin
            rd_act_q <= rd_act;
            if (rd_act) addr_q <= addr;
        end
    end

    // A read ends on the first clock where either enable has risen.
    always_comb begin
        rd_end  = rd_act_q & (ce_n | oe_n);
        rd_addr = addr_q;
    end

    // R10: a finished read cannot report its end twice in a row.
    assert_single_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_end |=> !rd_end);

endmodule

// File: rtl/rdseq_matcher.sv
// Module: rdseq_matcher
// Step counter that follows the seven-read address pattern. It reports an
// open or close hit when the last step matches.
// Assumes rd_end is a single-clock pulse and rd_addr is stable while it is high.
module rdseq_matcher
    import rdseq_wp_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_end,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_act,
    output logic              open_hit,
    output logic              close_hit
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

    logic [SEQ_LEN-1:0] step_match;
    logic               close_cmp;
    logic [STEP_W-1:0]  step_q;
    logic [STEP_W-1:0]  step_d;

    // One comparator per shared step; the last slot compares the open tail.
    for (genvar i = 0; i < SEQ_LEN - 1; i++) begin : g_prefix
        assign step_match[i] = (rd_addr == ADDR_W'(prefix_addr(i)));
    end
    assign step_match[SEQ_LEN-1] = (rd_addr == ADDR_W'(TAIL_OPEN));
    assign close_cmp             = (rd_addr == ADDR_W'(TAIL_CLOSE));

    // Next-step selection: abort on writes, advance on a match, else retry as step one.
    always_comb begin
        step_d    = step_q;
        open_hit  = 1'b0;
        close_hit = 1'b0;
        if (wr_act) begin
            step_d = '0;
        end else if (rd_end) begin
            if (step_q == LAST && step_match[SEQ_LEN-1]) begin
                open_hit = 1'b1;
                step_d   = '0;
            end else if (step_q == LAST && close_cmp) begin
                close_hit = 1'b1;
                step_d    = '0;
            end else if (step_q != LAST && step_match[step_q]) begin
                step_d = step_q + STEP_W'(1);
            end else begin
                step_d = step_match[0] ? STEP_W'(1) : '0;
            end
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    // R6: a write clock always leaves the matcher at step zero.
    assert_write_aborts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |=> step_q == '0);
    // R2: an open hit only ever comes from the final step.
    assert_open_from_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        open_hit |-> step_q == LAST);
    // R3: a close hit only ever comes from the final step.
    assert_close_from_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        close_hit |-> step_q == LAST);
    // R5: without a read end or a write, the step holds.
    assert_step_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_end && !wr_act) |=> $stable(step_q));

endmodule

// File: rtl/rdseq_wp_gate.sv
// Module: rdseq_wp_gate
// Holds the protect flag and gates program and erase requests against it.
// The gate uses the flag value from before any update in the same clock.
// Assumes open_hit and close_hit are never high together.
module rdseq_wp_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic open_hit,
    input  logic close_hit,
    input  logic prog_req,
    input  logic erase_req,
    output logic prog_go,
    output logic erase_go,
    output logic write_blocked,
    output logic wp_active
);

    logic wp_q;
    logic prog_go_q;
    logic erase_go_q;
    logic blocked_q;

    // Protect flag: set by reset or a close hit, cleared by an open hit.
    always_ff @(posedge clk) begin
        if (!rst_n)         wp_q <= 1'b1;
        else if (open_hit)  wp_q <= 1'b0;
        else if (close_hit) wp_q <= 1'b1;
    end

    // Request gating against the current (pre-update) flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_go_q  <= 1'b0;
            erase_go_q <= 1'b0;
            blocked_q  <= 1'b0;
        end else begin
            prog_go_q  <= prog_req  & ~wp_q;
            erase_go_q <= erase_req & ~wp_q;
            blocked_q  <= (prog_req | erase_req) & wp_q;
        end
    end

    assign prog_go       = prog_go_q;
    assign erase_go      = erase_go_q;
    assign write_blocked = blocked_q;
    assign wp_active     = wp_q;

    // R1: the first clock after reset shows the protected state.
    assert_reset_protected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> wp_q);
    // R7: the flag moves only after a matching seventh step.
    assert_flag_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wp_q) |-> $past(open_hit || close_hit));
    // R8: a request while protected is refused.
    assert_block_when_protected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((prog_req || erase_req) && wp_q) |=> (blocked_q && !prog_go_q && !erase_go_q));
    // R8: a program request while open is granted.
    assert_grant_when_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && !wp_q) |=> (prog_go_q && !blocked_q));

endmodule

// File: rtl/rdseq_wp_lock.sv
// Module: rdseq_wp_lock (top)
// Software write-protect lock. Seven-read address patterns toggle a protect
// flag, which gates program and erase requests. The data bus is not observed.
// Assumes all inputs are synchronous to clk.
module rdseq_wp_lock #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              prog_req,
    input  logic              erase_req,
    output logic              prog_go,
    output logic              erase_go,
    output logic              write_blocked,
    output logic              wp_active
);

    logic              rd_end;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_act;
    logic              open_hit;
    logic              close_hit;

    rdseq_strobe_track #(.ADDR_W(ADDR_W)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .rd_end  (rd_end),
        .rd_addr (rd_addr),
        .wr_act  (wr_act)
    );

    rdseq_matcher #(.ADDR_W(ADDR_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_end    (rd_end),
        .rd_addr   (rd_addr),
        .wr_act    (wr_act),
        .open_hit  (open_hit),
        .close_hit (close_hit)
    );

    rdseq_wp_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .open_hit      (open_hit),
        .close_hit     (close_hit),
        .prog_req      (prog_req),
        .erase_req     (erase_req),
        .prog_go       (prog_go),
        .erase_go      (erase_go),
        .write_blocked (write_blocked),
        .wp_active     (wp_active)
    );

    // R2/R3: the two hit kinds never fire in the same clock.
    assert_hits_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_hit && close_hit));

endmodule

// File: tb/tb_rdseq_wp_lock.sv
module tb_rdseq_wp_lock;

    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic          prog_req = 1'b0, erase_req = 1'b0;
    logic          prog_go, erase_go, write_blocked, wp_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rdseq_wp_lock #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .prog_req(prog_req), .erase_req(erase_req),
        .prog_go(prog_go), .erase_go(erase_go),
        .write_blocked(write_blocked), .wp_active(wp_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // mode 0: both enables rise; 1: only oe_n rises; 2: only ce_n rises, address changes
    task automatic do_read(input logic [15:0] a, input int hold, input int mode);
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (hold) @(negedge clk);
        if (mode == 1) oe_n = 1'b1;
        else if (mode == 2) begin ce_n = 1'b1; addr = AW'(19'h7FFFF); end
        else begin ce_n = 1'b1; oe_n = 1'b1; end
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic prefix6();
        do_read(16'h1823, 1, 0); do_read(16'h1820, 1, 0); do_read(16'h1822, 1, 0);
        do_read(16'h0418, 1, 0); do_read(16'h041B, 1, 0); do_read(16'h0419, 1, 0);
    endtask

    task automatic do_unlock(); prefix6(); do_read(16'h041A, 1, 0); endtask
    task automatic do_lock();   prefix6(); do_read(16'h040A, 1, 0); endtask

    // Pulse a request and return the {prog_go, erase_go, write_blocked} seen.
    task automatic request(input bit prog, output logic [2:0] resp);
        prog_req = prog; erase_req = !prog;
        @(negedge clk);
        prog_req = 1'b0; erase_req = 1'b0;
        resp = {prog_go, erase_go, write_blocked};
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [2:0] r;
        check("R1 wp_active after reset", wp_active, 1);
        check("R1 outputs idle after reset", {prog_go, erase_go, write_blocked}, 0);
        request(1'b1, r);
        check("R8 prog refused while protected", r, 3'b001);
    endtask

    task automatic t_unlock();
        logic [2:0] r;
        prefix6();
        check("R7 six steps leave protection", wp_active, 1);
        do_read(16'h041A, 1, 0);
        check("R2 open sequence clears protect", wp_active, 0);
        request(1'b1, r);
        check("R8 prog granted when open", r, 3'b100);
        request(1'b0, r);
        check("R8 erase granted when open", r, 3'b010);
    endtask

    task automatic t_lock();
        logic [2:0] r;
        do_lock();
        check("R3 close sequence sets protect", wp_active, 1);
        request(1'b0, r);
        check("R8 erase refused while protected", r, 3'b001);
    endtask

    task automatic t_wrong_tail();
        prefix6(); do_read(16'h0419, 1, 0);
        check("R7 wrong seventh address", wp_active, 1);
        do_read(16'h041A, 1, 0);
        check("R7 stray tail after reset of matcher", wp_active, 1);
    endtask

    task automatic t_restart();
        do_read(16'h1823, 1, 0); do_read(16'h1820, 1, 0);
        do_read(16'h1823, 1, 0);
        do_read(16'h1820, 1, 0); do_read(16'h1822, 1, 0); do_read(16'h0418, 1, 0);
        do_read(16'h041B, 1, 0); do_read(16'h0419, 1, 0); do_read(16'h041A, 1, 0);
        check("R5 mismatch re-tried as step one", wp_active, 0);
        do_lock();
        check("R3 relock after restart test", wp_active, 1);
    endtask

    task automatic t_write_abort();
        do_read(16'h1823, 1, 0); do_read(16'h1820, 1, 0); do_read(16'h1822, 1, 0);
        ce_n = 1'b0; we_n = 1'b0; addr = AW'(16'h0418);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        do_read(16'h0418, 1, 0); do_read(16'h041B, 1, 0);
        do_read(16'h0419, 1, 0); do_read(16'h041A, 1, 0);
        check("R6 write aborts sequence", wp_active, 1);
    endtask

    task automatic t_end_variants();
        do_read(16'h1823, 1, 1); do_read(16'h1820, 1, 2); do_read(16'h1822, 1, 1);
        do_read(16'h0418, 1, 2); do_read(16'h041B, 1, 0); do_read(16'h0419, 1, 1);
        do_read(16'h041A, 1, 2);
        check("R4 end by either enable, old address used", wp_active, 0);
    endtask

    task automatic t_long_read();
        do_read(16'h1823, 3, 0); do_read(16'h1820, 4, 1); do_read(16'h1822, 2, 0);
        do_read(16'h0418, 1, 0); do_read(16'h041B, 5, 0); do_read(16'h0419, 1, 0);
        do_read(16'h040A, 3, 0);
        check("R10 long reads count once", wp_active, 1);
    endtask

    task automatic t_same_cycle();
        logic [2:0] r;
        prefix6();
        addr = AW'(16'h041A); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; prog_req = 1'b1;
        @(negedge clk);
        prog_req = 1'b0;
        check("R9 request in flip clock sees old flag", {prog_go, write_blocked}, 2'b01);
        check("R9 flag flipped in same clock", wp_active, 0);
        @(negedge clk);
        request(1'b1, r);
        check("R9 following request granted", r, 3'b100);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unlock();
        t_lock();
        t_wrong_tail();
        t_restart();
        t_write_abort();
        t_end_variants();
        t_long_read();
        t_same_cycle();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule